// File: doc/BRIEF.md
# Weight-Shared Bin-Accumulate MAC Unit

This block computes the dot product of a data vector with a weight vector in a convolution engine whose weights have been clustered into a small set of shared values. Each input beat carries a signed data value and a short bin index instead of a full weight. While a vector streams in, the unit does no multiplication: it adds each data value into one running sum per bin, chosen by the beat's index. This phase needs only adders and selection logic.

When the beat marked last has been taken, the unit enters a multiply phase. It stops accepting input and steps once through the bins. In each cycle a single signed multiplier forms one bin sum times that bin's shared weight, and this product is added to the total. The shared weights sit in a small register table that is loaded through its own write port. After the final bin the total is presented with a one-cycle valid pulse. All bin sums then return to zero for the next vector. Compared with a direct MAC, each vector costs NUM_BINS extra cycles.

Top module: `wsh_bin_mac`

## Requirements
- R1: After reset, `res_valid` is 0, `in_ready` is 1 and every bin sum and table entry is zero.
- R2: `in_ready` is 1 throughout the accumulate phase. After the edge that accepts a beat with `in_last`=1, `in_ready` is 0 for exactly NUM_BINS cycles.
- R3: A beat counts only when `in_valid` and `in_ready` are both 1. Its data is added into bin number `in_bin`. Beats offered with `in_valid`=0, or while `in_ready`=0, change no sum.
- R4: `res_data` equals the signed sum, over all accepted beats of the vector, of `in_data` times table[`in_bin`], using the table contents at the start of the multiply phase.
- R5: `res_valid` rises on the same edge at which `in_ready` returns to 1, and it stays high for one cycle only.
- R6: Every bin sum is zero after a result is issued, so one vector has no effect on the next.
- R7: A write with `wt_we`=1 and `in_ready`=1 stores `wt_data` at entry `wt_addr` and is used by the next multiply phase. A write while `in_ready`=0 is ignored.
- R8: A vector of one beat gives data times the weight of its bin.
- R9: A vector of MAX_LEN beats, all in one bin, gives an exact result even at the extreme values -128 and 127 for data and weight.
- R10: `res_data` keeps its value in every cycle in which `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Unit can accept a beat (accumulate phase) |
| in_data | input | DATA_W | Signed data value |
| in_bin | input | IDX_W | Bin index of this element's weight |
| in_last | input | 1 | Final beat of the vector |
| wt_we | input | 1 | Weight table write enable |
| wt_addr | input | IDX_W | Weight table entry |
| wt_data | input | WGT_W | Signed shared weight value |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | RES_W | Signed dot product |

## Verification
A bin sum that is wrong, stale or not cleared appears only in `res_data`, exactly NUM_BINS cycles after the last beat of the affected vector. A leftover value from an earlier vector shows up in the result of the next one. For this reason, the vectors are compared one after another against a dot product computed in the bench, and the sequence includes single-beat vectors and full-length vectors confined to one bin. A fault in the phase control shows at once as a wrong count of cycles with `in_ready` low, or as a misplaced `res_valid` pulse. Junk beats and table writes are offered while the unit is busy, so that a leak through the gating corrupts the next result.

// File: rtl/wsh_pkg.sv
`timescale 1ns/1ps
package wsh_pkg;
  typedef enum logic {
    PH_ACC = 1'b0,
    PH_MUL = 1'b1
  } phase_t;
endpackage

// File: rtl/wsh_bin_bank.sv
`timescale 1ns/1ps
// One running sum per bin; the index selects which sum takes the data value.
module wsh_bin_bank #(
  parameter int NUM_BINS = 16,
  parameter int DATA_W   = 8,
  parameter int ACC_W    = 16,
  parameter int IDX_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     add_en,
  input  logic [IDX_W-1:0]         add_idx,
  input  logic [DATA_W-1:0]        add_data,
  input  logic                     clr,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic signed [ACC_W-1:0]  rd_acc
);
  localparam int EXT_W = ACC_W - DATA_W;

  logic [ACC_W-1:0] data_ext;
  logic [ACC_W-1:0] acc_q [NUM_BINS];

  assign data_ext = {{EXT_W{add_data[DATA_W-1]}}, add_data};

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    logic             hit;
    logic [ACC_W-1:0] acc_d;

    assign hit = add_en && (add_idx == IDX_W'(b));

    always_comb begin
      acc_d = acc_q[b];
      if (clr) begin
        acc_d = '0;
      end else if (hit) begin
        acc_d = acc_q[b] + data_ext;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[b] <= '0;
      end else if (clr || hit) begin
        acc_q[b] <= acc_d;
      end
    end
  end

  assign rd_acc = $signed(acc_q[rd_idx]);
endmodule

// File: rtl/wsh_wtab.sv
`timescale 1ns/1ps
// Shared weight values, one register per bin.
module wsh_wtab #(
  parameter int NUM_BINS = 16,
  parameter int WGT_W    = 8,
  parameter int IDX_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IDX_W-1:0]         addr,
  input  logic [WGT_W-1:0]         wdata,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic signed [WGT_W-1:0]  rd_w
);
  logic [WGT_W-1:0] tab_q [NUM_BINS];

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_ent
    logic wr_en;
    assign wr_en = we && (addr == IDX_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tab_q[b] <= '0;
      end else if (wr_en) begin
        tab_q[b] <= wdata;
      end
    end
  end

  assign rd_w = $signed(tab_q[rd_idx]);
endmodule

// File: rtl/wsh_mul_seq.sv
`timescale 1ns/1ps
// Phase control and the multiply phase: one bin per cycle on one multiplier.
module wsh_mul_seq
  import wsh_pkg::*;
#(
  parameter int NUM_BINS = 16,
  parameter int ACC_W    = 16,
  parameter int WGT_W    = 8,
  parameter int IDX_W    = 4,
  parameter int RES_W    = 28
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_fire,
  input  logic                     in_last,
  input  logic signed [ACC_W-1:0]  acc_val,
  input  logic signed [WGT_W-1:0]  wt_val,
  output logic                     busy,
  output logic [IDX_W-1:0]         rd_idx,
  output logic                     clr,
  output logic                     res_valid,
  output logic [RES_W-1:0]         res_data
);
  localparam int PROD_W = ACC_W + WGT_W;
  localparam int PAD_W  = RES_W - PROD_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BINS - 1);

  phase_t             phase_q, phase_d;
  logic [IDX_W-1:0]   cnt_q, cnt_d;
  logic [RES_W-1:0]   sum_q, sum_d;
  logic [RES_W-1:0]   res_q, res_d;
  logic               vld_q, vld_d;
  logic signed [PROD_W-1:0] prod;
  logic [RES_W-1:0]   prod_ext;
  logic [RES_W-1:0]   sum_nxt;

  assign prod     = acc_val * wt_val;
  assign prod_ext = {{PAD_W{prod[PROD_W-1]}}, prod};
  assign sum_nxt  = sum_q + prod_ext;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    sum_d   = sum_q;
    res_d   = res_q;
    vld_d   = 1'b0;
    clr     = 1'b0;
    unique case (phase_q)
      PH_ACC: begin
        if (in_fire && in_last) begin
          phase_d = PH_MUL;
          cnt_d   = '0;
          sum_d   = '0;
        end
      end
      PH_MUL: begin
        sum_d = sum_nxt;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_IDX) begin
          res_d   = sum_nxt;
          vld_d   = 1'b1;
          clr     = 1'b1;
          phase_d = PH_ACC;
        end
      end
      default: phase_d = PH_ACC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ACC;
      cnt_q   <= '0;
      sum_q   <= '0;
      res_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      sum_q   <= sum_d;
      vld_q   <= vld_d;
      if (vld_d) begin
        res_q <= res_d;
      end
    end
  end

  assign busy      = (phase_q == PH_MUL);
  assign rd_idx    = cnt_q;
  assign res_valid = vld_q;
  assign res_data  = res_q;
endmodule

// File: rtl/wsh_bin_mac.sv
`timescale 1ns/1ps
module wsh_bin_mac #(
  parameter int NUM_BINS = 16,
  parameter int DATA_W   = 8,
  parameter int WGT_W    = 8,
  parameter int MAX_LEN  = 256,
  localparam int IDX_W   = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1,
  localparam int ACC_W   = DATA_W + $clog2(MAX_LEN),
  localparam int RES_W   = ACC_W + WGT_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [IDX_W-1:0]  in_bin,
  input  logic              in_last,
  input  logic              wt_we,
  input  logic [IDX_W-1:0]  wt_addr,
  input  logic [WGT_W-1:0]  wt_data,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_data
);
  logic                    rst_s1_q, rst_s2_q;
  logic                    busy;
  logic                    in_fire;
  logic                    clr;
  logic [IDX_W-1:0]        rd_idx;
  logic signed [ACC_W-1:0] acc_val;
  logic signed [WGT_W-1:0] wt_val;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  assign in_ready = !busy;
  assign in_fire  = in_valid && in_ready;

  wsh_bin_bank #(
    .NUM_BINS(NUM_BINS), .DATA_W(DATA_W), .ACC_W(ACC_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_s2_q),
    .add_en(in_fire), .add_idx(in_bin), .add_data(in_data),
    .clr(clr), .rd_idx(rd_idx), .rd_acc(acc_val)
  );

  wsh_wtab #(
    .NUM_BINS(NUM_BINS), .WGT_W(WGT_W), .IDX_W(IDX_W)
  ) u_wtab (
    .clk(clk), .rst_n(rst_s2_q),
    .we(wt_we && !busy), .addr(wt_addr), .wdata(wt_data),
    .rd_idx(rd_idx), .rd_w(wt_val)
  );

  wsh_mul_seq #(
    .NUM_BINS(NUM_BINS), .ACC_W(ACC_W), .WGT_W(WGT_W),
    .IDX_W(IDX_W), .RES_W(RES_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_s2_q),
    .in_fire(in_fire), .in_last(in_last),
    .acc_val(acc_val), .wt_val(wt_val),
    .busy(busy), .rd_idx(rd_idx), .clr(clr),
    .res_valid(res_valid), .res_data(res_data)
  );
endmodule

// File: rtl/wsh_bin_mac_chk.sv
`timescale 1ns/1ps
module wsh_bin_mac_chk #(
  parameter int NUM_BINS = 16,
  parameter int RES_W    = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_last,
  input logic             res_valid,
  input logic [RES_W-1:0] res_data
);
  localparam int CW = $clog2(NUM_BINS + 1) + 1;

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (!in_ready) begin
      low_cnt <= low_cnt + 1'b1;
    end else begin
      low_cnt <= '0;
    end
  end

  // R2: ready only drops right after an accepted last beat
  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && $past(in_ready)) |-> $past(in_valid && in_last));

  // R2: the busy window is exactly NUM_BINS cycles long
  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (low_cnt == CW'(NUM_BINS)));

  // R5: result strobe lasts one cycle
  assert_one_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R5: result coincides with ready returning
  assert_ready_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (in_ready && $past(!in_ready)));

  // R10: result holds between strobes
  assert_res_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_data));
endmodule

bind wsh_bin_mac wsh_bin_mac_chk #(.NUM_BINS(NUM_BINS), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .res_valid(res_valid), .res_data(res_data)
);

// File: tb/wsh_bin_mac_bench.sv
`timescale 1ns/1ps
module wsh_bin_mac_bench;
  localparam int NB = 16;
  localparam int DW = 8;
  localparam int WW = 8;
  localparam int ML = 256;
  localparam int IW = 4;
  localparam int RW = (DW + 8) + WW + IW;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [DW-1:0] in_data;
  logic [IW-1:0] in_bin;
  logic          in_last;
  logic          wt_we;
  logic [IW-1:0] wt_addr;
  logic [WW-1:0] wt_data;
  logic          res_valid;
  logic [RW-1:0] res_data;

  int checks;
  int errors;
  bit done;
  longint wt_m [NB];
  longint exp_sum;

  wsh_bin_mac u_wsh_bin_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_bin(in_bin), .in_last(in_last),
    .wt_we(wt_we), .wt_addr(wt_addr), .wt_data(wt_data),
    .res_valid(res_valid), .res_data(res_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_w(input int idx, input longint val);
    @(negedge clk);
    wt_we   = 1'b1;
    wt_addr = IW'(idx);
    wt_data = WW'(val);
    wt_m[idx] = val;
    @(negedge clk);
    wt_we = 1'b0;
  endtask

  // mode 0: random data/bins with bubbles; 1: fixed bin and data
  task automatic run_vec(input int n, input int mode, input int fbin, input int fdat);
    longint held;
    int low;
    exp_sum = 0;
    for (int i = 0; i < n; i++) begin
      int d;
      int b;
      if (mode == 0 && ($urandom % 4) == 0) begin
        @(negedge clk);
        in_valid = 1'b0;         // R3: bubble beat carries junk, must not count
        in_data  = DW'($urandom);
        in_bin   = IW'($urandom);
        in_last  = 1'b1;
      end
      d = (mode == 0) ? (int'($urandom % 256) - 128) : fdat;
      b = (mode == 0) ? int'($urandom % NB) : fbin;
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = DW'(d);
      in_bin   = IW'(b);
      in_last  = (i == n - 1);
      exp_sum += longint'(d) * wt_m[b];
    end
    low = 0;
    forever begin
      @(negedge clk);
      if (in_ready || low > 4 * NB) break;
      low++;
      in_valid = 1'b1;           // R3: offered while busy, must be ignored
      in_data  = DW'($urandom);
      in_bin   = IW'($urandom);
      in_last  = 1'b0;
      wt_we    = 1'b1;           // R7: write while busy, must be ignored
      wt_addr  = IW'($urandom);
      wt_data  = WW'($urandom);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    wt_we    = 1'b0;
    chk(low == NB, "R2 busy cycles", low, NB);
    chk(res_valid == 1'b1, "R5 strobe with ready", res_valid, 1);
    chk(longint'($signed(res_data)) == exp_sum, "R4 dot product",
        longint'($signed(res_data)), exp_sum);
    held = longint'($signed(res_data));
    @(negedge clk);
    chk(res_valid == 1'b0, "R5 one-cycle strobe", res_valid, 0);
    chk(longint'($signed(res_data)) == held, "R10 result held",
        longint'($signed(res_data)), held);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_bin = '0; in_last = 1'b0;
    wt_we = 1'b0; wt_addr = '0; wt_data = '0;
    for (int b = 0; b < NB; b++) wt_m[b] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(res_valid == 1'b0, "R1 valid low", res_valid, 0);
    chk(in_ready == 1'b1, "R1 ready high", in_ready, 1);
    chk(res_data == '0, "R1 result zero", longint'(res_data), 0);
    // R1: zero table and sums give zero
    run_vec(5, 0, 0, 0);

    // R7: load a table and use it
    for (int b = 0; b < NB; b++) wr_w(b, longint'(b * 17 % 256) - 128);
    for (int v = 0; v < 20; v++) run_vec(1 + int'($urandom % 40), 0, 0, 0);

    // R8: single-beat vectors, each bin and a sweep of data values
    for (int b = 0; b < NB; b++) run_vec(1, 1, b, (b * 37 % 256) - 128);

    // R9: full-length vectors in one bin at the extremes
    wr_w(3, -128);
    run_vec(ML, 1, 3, -128);
    run_vec(ML, 1, 3, 127);
    wr_w(12, 127);
    run_vec(ML, 1, 12, -128);

    // R6: after a large vector, a short one must see clean sums
    wr_w(5, 1);
    run_vec(1, 1, 5, 77);
    chk(longint'($signed(res_data)) == 77, "R6 cleared sums",
        longint'($signed(res_data)), 77);

    // R7: rewrite table with new values, random vectors again
    for (int b = 0; b < NB; b++) wr_w(b, longint'($urandom % 256) - 128);
    for (int v = 0; v < 20; v++) run_vec(1 + int'($urandom % 64), 0, 0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule